// File: doc/BRIEF.md
# Linear Spectral Sensor Scan Sequencer

This block drives a linear CMOS spectral sensor with 256 pixels. It makes the sensor clock from the system clock. It raises and lowers the start line that opens and closes each exposure. It marks every pixel slot of the readout for the capture logic downstream, and it counts the exposures. The exposure length comes from how long the start line stays high. The number of exposures comes from how many start pulses are issued.

A host sends a 16-bit command word. A mode bit selects one of two behaviours:
- **Continuous:** a fixed 100 ms exposure that repeats without end.
- **User:** an exposure of 5 ms to 100 ms in 5 ms steps, repeated 1 to 100 times, after which the block returns to standby.

The command input is a valid/ready stream with a holding register one entry deep:
- A word is taken on any cycle where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` drops while a word is held, so a second word back-pressures the host until the held word starts a scan.
- A word that arrives during a scan never alters that scan. It is applied at the first scan start after the sensor signals end of scan.

The pixel strobe has no ready input, because the sensor cannot be stalled. Downstream logic must accept one pixel per slot.

Top module: `spectro_scan_driver`

## Requirements
- R1: After reset the start line and pixel strobe are low, `cmd_ready` is high, and no start pulse is issued until a command word has been accepted.
- R2: Command layout: bit 15 set selects user mode and clear selects continuous mode; bits 14..10 are the exposure code (units of 5 ms); bits 6..0 are the scan count; bits 9..7 have no effect.
- R3: In user mode the start line stays high for exactly code × STEP_SCLK sensor clock periods for every code from 1 to 20.
- R4: An exposure code of 0 acts as 1 and a code above 20 acts as 20; a scan count of 0 acts as 1 and a count above 100 acts as 100.
- R5: In user mode exactly the requested number of start pulses is issued, after which the block stays in standby with the start line low.
- R6: In continuous mode the exposure is 20 units (100 ms) whatever bits 14..0 hold, and scans repeat until a new command is taken.
- R7: After each falling edge of the start line, PIXELS single-cycle strobes follow. They come one every 4 sensor clock periods, the first 4 periods after the fall. Their indices run 0 to PIXELS-1 in order, and no strobe occurs while the start line is high.
- R8: The sensor clock period is 2 × SCLK_HALF system clocks. Every edge of the start line coincides with a rising edge of the sensor clock.
- R9: A command accepted during a scan leaves that scan's exposure unchanged and governs the scans that start after the end-of-scan pulse.
- R10: `cmd_ready` is low while a command is held and returns high in the cycle that command raises the start line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Holding register free; word taken when valid and ready |
| cmd_data | input | 16 | Command word (layout in R2) |
| sclk | output | 1 | Sensor clock |
| st | output | 1 | Start line; its high time sets the exposure |
| eos | input | 1 | End-of-scan pulse from the sensor |
| pix_valid | output | 1 | One-cycle strobe per pixel slot |
| pix_index | output | $clog2(PIXELS) | Index of the current pixel slot |

## Verification
The bench sweeps every exposure code from 1 to 20 and sends codes and counts on both sides of the legal ranges. A missing or one-sided clamp shows up as a zero-length or over-long start pulse, or as a wrong number of scans. It fills the don't-care bits and drives continuous mode with junk fields. A decoder that reads the wrong bits shows up as a changed exposure. It then interrupts a continuous run mid-exposure with a user command. A design that applied commands at once would shorten the running exposure. A design that never re-armed the handshake would hold `cmd_ready` low. Pixel strobes are timed against the start line's fall. An off-by-one slot counter shows up as a shifted first strobe, a wrong spacing, or a missing or extra index.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int CMD_W  = 16;
  localparam int CODE_W = 5;
  localparam int CNT_W  = 7;

  typedef enum logic [1:0] {
    S_IDLE,
    S_INTEG,
    S_READ,
    S_WAIT
  } seq_state_t;

  typedef struct packed {
    logic              user;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  scans;
  } scan_cfg_t;
endpackage

// File: rtl/ssd_clkgen.sv
module ssd_clkgen #(
  parameter int HALF = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF - 1));
  assign rise = wrap & ~sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/ssd_cmd_hold.sv
module ssd_cmd_hold
  import ssd_pkg::*;
#(
  parameter int MAX_CODE  = 20,
  parameter int MAX_SCANS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             cmd_ready,
  input  logic             take,
  output scan_cfg_t        held,
  output logic             held_v
);
  logic [CODE_W-1:0] raw_code, fix_code;
  logic [CNT_W-1:0]  raw_cnt, fix_cnt;
  logic              unused_bits;

  assign raw_code    = cmd_data[14:10];
  assign raw_cnt     = cmd_data[6:0];
  assign unused_bits = ^cmd_data[9:7];
  assign cmd_ready   = ~held_v;

  always_comb begin
    fix_code = raw_code;
    if (raw_code == '0)                       fix_code = CODE_W'(1);
    else if (raw_code > CODE_W'(MAX_CODE))    fix_code = CODE_W'(MAX_CODE);
    fix_cnt = raw_cnt;
    if (raw_cnt == '0)                        fix_cnt = CNT_W'(1);
    else if (raw_cnt > CNT_W'(MAX_SCANS))     fix_cnt = CNT_W'(MAX_SCANS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held   <= '0;
    end else if (cmd_valid && !held_v) begin
      held_v     <= 1'b1;
      held.user  <= cmd_data[15];
      held.code  <= fix_code;
      held.scans <= fix_cnt;
    end else if (take) begin
      held_v <= 1'b0;
    end
  end
endmodule

// File: rtl/ssd_sequencer.sv
module ssd_sequencer
  import ssd_pkg::*;
#(
  parameter int PIXELS       = 256,
  parameter int STEP_SCLK    = 4000,
  parameter int MAX_CODE     = 20,
  parameter int DEFAULT_CODE = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              eos,
  input  logic              held_v,
  input  scan_cfg_t         held,
  output logic              take,
  output logic              st,
  output logic              pix_valid,
  output logic [$clog2(PIXELS)-1:0] pix_index
);
  localparam int PW = $clog2(PIXELS);
  localparam int IW = $clog2(MAX_CODE * STEP_SCLK);

  seq_state_t        state;
  logic              user_r, run_r;
  logic [CODE_W-1:0] code_r, new_code;
  logic [CNT_W-1:0]  left_r;
  logic [IW-1:0]     icnt;
  logic [1:0]        sub;
  logic [PW-1:0]     pix;
  logic              start_new, start_again, finish;

  function automatic logic [IW-1:0] integ_len(input logic [CODE_W-1:0] c);
    return IW'(c) * IW'(STEP_SCLK) - IW'(1);
  endfunction

  assign new_code    = held.user ? held.code : CODE_W'(DEFAULT_CODE);
  assign start_new   = (state == S_IDLE) && rise && held_v;
  assign start_again = (state == S_IDLE) && rise && !held_v && run_r;
  assign take        = start_new;
  assign finish      = eos && ((state == S_READ) || (state == S_WAIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      user_r    <= 1'b0;
      run_r     <= 1'b0;
      code_r    <= '0;
      left_r    <= '0;
      icnt      <= '0;
      sub       <= '0;
      pix       <= '0;
      st        <= 1'b0;
      pix_valid <= 1'b0;
      pix_index <= '0;
    end else begin
      pix_valid <= 1'b0;
      if (finish) begin
        state <= S_IDLE;
        if (user_r) begin
          left_r <= left_r - CNT_W'(1);
          run_r  <= (left_r > CNT_W'(1));
        end else begin
          run_r <= 1'b1;
        end
      end else begin
        case (state)
          S_IDLE: begin
            if (start_new) begin
              user_r <= held.user;
              code_r <= new_code;
              left_r <= held.scans;
              run_r  <= 1'b1;
              st     <= 1'b1;
              icnt   <= integ_len(new_code);
              state  <= S_INTEG;
            end else if (start_again) begin
              st    <= 1'b1;
              icnt  <= integ_len(code_r);
              state <= S_INTEG;
            end
          end
          S_INTEG: begin
            if (rise) begin
              if (icnt == '0) begin
                st    <= 1'b0;
                sub   <= '0;
                pix   <= '0;
                state <= S_READ;
              end else begin
                icnt <= icnt - IW'(1);
              end
            end
          end
          S_READ: begin
            if (rise) begin
              sub <= sub + 2'd1;
              if (sub == 2'd3) begin
                pix_valid <= 1'b1;
                pix_index <= pix;
                if (pix == PW'(PIXELS - 1)) state <= S_WAIT;
                else                        pix   <= pix + PW'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spectro_scan_driver.sv
module spectro_scan_driver
  import ssd_pkg::*;
#(
  parameter int SCLK_HALF    = 125,
  parameter int PIXELS       = 256,
  parameter int STEP_SCLK    = 4000,
  parameter int MAX_CODE     = 20,
  parameter int DEFAULT_CODE = 20,
  parameter int MAX_SCANS    = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [15:0]               cmd_data,
  output logic                      sclk,
  output logic                      st,
  input  logic                      eos,
  output logic                      pix_valid,
  output logic [$clog2(PIXELS)-1:0] pix_index
);
  logic      rise, take, held_v;
  scan_cfg_t held;

  ssd_clkgen #(.HALF(SCLK_HALF)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise)
  );

  ssd_cmd_hold #(.MAX_CODE(MAX_CODE), .MAX_SCANS(MAX_SCANS)) hold_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .take(take), .held(held), .held_v(held_v)
  );

  ssd_sequencer #(
    .PIXELS(PIXELS), .STEP_SCLK(STEP_SCLK),
    .MAX_CODE(MAX_CODE), .DEFAULT_CODE(DEFAULT_CODE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .rise(rise), .eos(eos),
    .held_v(held_v), .held(held), .take(take),
    .st(st), .pix_valid(pix_valid), .pix_index(pix_index)
  );
endmodule

// File: rtl/spectro_scan_driver_chk.sv
module spectro_scan_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic sclk,
  input logic st,
  input logic pix_valid
);
  // R8
  st_edge_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st) || $fell(st)) |-> $rose(sclk));

  // R7
  pix_outside_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !st);

  // R7
  pix_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  // R8
  pix_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $rose(sclk));

  // R10
  ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> $rose(st));
endmodule

bind spectro_scan_driver spectro_scan_driver_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .sclk(sclk), .st(st), .pix_valid(pix_valid)
);

// File: tb/spectro_scan_driver_tb.sv
module spectro_scan_driver_tb_top;
  localparam int HALF = 2;
  localparam int PIX  = 8;
  localparam int STEP = 3;
  localparam int UNIT = STEP * 2 * HALF;   // system clocks per exposure code
  localparam int SLOT = 4 * 2 * HALF;      // system clocks per pixel slot

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        eos = 1'b0;
  logic        cmd_ready, sclk, st, pix_valid;
  logic [2:0]  pix_index;

  int total = 0, bad = 0;
  int cyc = 0, last_srise = 0, st_len = 0, since_fall = 0, pix_seen = 0;
  int scans_seen = 0, eos_timer = 0, act_len = 0, pend_len = 0, target = 0;
  bit pend_v = 0, st_q = 0, sclk_q = 0;
  string cur_tag = "R3";

  always #2.5 clk = ~clk;

  spectro_scan_driver #(
    .SCLK_HALF(HALF), .PIXELS(PIX), .STEP_SCLK(STEP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .sclk(sclk), .st(st), .eos(eos),
    .pix_valid(pix_valid), .pix_index(pix_index)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int calc_len(input logic [15:0] w);
    int c;
    if (!w[15]) c = 20;
    else begin
      c = int'(w[14:10]);
      if (c < 1) c = 1;
      if (c > 20) c = 20;
    end
    return c * UNIT;
  endfunction

  function automatic int calc_scans(input logic [15:0] w);
    int n;
    n = int'(w[6:0]);
    if (n < 1) n = 1;
    if (n > 100) n = 100;
    return n;
  endfunction

  // monitor and sensor end-of-scan model
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (sclk && !sclk_q) begin
        if (last_srise > 0) chk(cyc - last_srise == 2 * HALF, "R8", cyc - last_srise, 2 * HALF);
        last_srise = cyc;
      end
      if (st && !st_q) begin
        chk(sclk && !sclk_q, "R8", int'(sclk), 1);
        if (scans_seen > 0) chk(pix_seen == PIX, "R7", pix_seen, PIX);
        if (pend_v) begin act_len = pend_len; pend_v = 0; end
        st_len = 0;
      end
      if (st) st_len++;
      if (!st && st_q) begin
        chk(st_len == act_len, cur_tag, st_len, act_len);
        scans_seen++;
        since_fall = 0;
        pix_seen = 0;
      end else begin
        since_fall++;
      end
      if (pix_valid) begin
        chk(!st, "R7", int'(st), 0);
        chk(since_fall == SLOT * (pix_seen + 1), "R7", since_fall, SLOT * (pix_seen + 1));
        chk(int'(pix_index) == pix_seen, "R7", int'(pix_index), pix_seen);
        pix_seen++;
        if (pix_seen == PIX) eos_timer = 3;
      end
      eos = 1'b0;
      if (eos_timer > 0) begin
        eos_timer--;
        if (eos_timer == 0) eos = 1'b1;
      end
      sclk_q = sclk;
      st_q = st;
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    pend_len  = calc_len(w);
    pend_v    = 1;
  endtask

  task automatic wait_scans(input int n, input string tag);
    int g = 0;
    while (scans_seen < n && g < 40000) begin @(negedge clk); g++; end
    chk(scans_seen >= n, tag, scans_seen, n);
  endtask

  task automatic run_user(input logic [15:0] w, input string tag);
    cur_tag = tag;
    send(w);
    target += calc_scans(w);
    wait_scans(target, tag);
    repeat (200) @(negedge clk);
    chk(scans_seen == target, tag, scans_seen, target);
    chk(st == 1'b0, tag, int'(st), 0);
    chk(pix_seen == PIX, "R7", pix_seen, PIX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(st == 1'b0, "R1", int'(st), 0);
    chk(pix_valid == 1'b0, "R1", int'(pix_valid), 0);
    chk(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
    repeat (150) @(negedge clk);
    chk(scans_seen == 0 && st == 1'b0, "R1", scans_seen, 0);

    // R3 sweep of all legal exposure codes, one scan each
    for (int c = 1; c <= 20; c++) run_user({1'b1, 5'(c), 3'b000, 7'd1}, "R3");

    // R4 code clamps
    run_user({1'b1, 5'd0,  3'b000, 7'd1}, "R4");
    run_user({1'b1, 5'd21, 3'b000, 7'd1}, "R4");
    run_user({1'b1, 5'd31, 3'b000, 7'd1}, "R4");

    // R5 scan counts
    run_user({1'b1, 5'd1, 3'b000, 7'd2}, "R5");
    run_user({1'b1, 5'd3, 3'b000, 7'd3}, "R5");
    run_user({1'b1, 5'd1, 3'b000, 7'd5}, "R5");

    // R4 count clamps
    run_user({1'b1, 5'd1, 3'b000, 7'd0},   "R4");
    run_user({1'b1, 5'd1, 3'b000, 7'd127}, "R4");

    // R2 ignored bits 9..7
    run_user({1'b1, 5'd2, 3'b111, 7'd2}, "R2");

    // R6 continuous mode with junk fields
    cur_tag = "R6";
    send(16'h4C83);
    wait_scans(target + 3, "R6");
    target += 3;
    begin
      int g = 0;
      while (!st && g < 2000) begin @(negedge clk); g++; end
      chk(st == 1'b1, "R6", int'(st), 1);
    end
    // R9 user command mid-exposure; running scan keeps continuous length
    cur_tag = "R9";
    send({1'b1, 5'd2, 3'b000, 7'd2});
    // R10 held word blocks the input
    chk(cmd_ready == 1'b0, "R10", int'(cmd_ready), 0);
    begin
      int g = 0;
      while (st && g < 2000) begin @(negedge clk); g++; end
      g = 0;
      while (!st && g < 2000) begin @(negedge clk); g++; end
      chk(cmd_ready == 1'b1, "R10", int'(cmd_ready), 1);
    end
    target += 3;
    wait_scans(target, "R9");
    repeat (200) @(negedge clk);
    chk(scans_seen == target, "R5", scans_seen, target);
    chk(st == 1'b0, "R5", int'(st), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule